// File: doc/BRIEF.md
# Serial Register Access Controller

This block is the slave side of a four-wire serial port for a converter's register file. The host drives a serial clock, an active-low select and a data-in line, and reads a data-out line. Every exchange opens with an 8-bit command byte, sent most significant bit first. The command byte chooses read or write, sets two power-control bits and addresses one of four registers. The controller then moves that register's contents in or out, also most significant bit first, and goes back to waiting for the next command.

The register storage is inside the block. It holds an 8-bit status word, a 24-bit configuration word, an 8-bit filter word and a 16-bit conversion result that the host can only read. The result is loaded from the converter side through a valid strobe, which also raises a ready flag. The serial pins are oversampled by the system clock, so the serial clock must run several times slower than `clk_i`.

The command phase begins only on a zero gate bit, and leading ones are ignored. A run of 32 consecutive ones on the data line puts the port and every register back to the reset state. This lets a host recover after it loses framing.

Top module: `sac_serial_regs`

## Requirements
- R1: After reset, `dout_oe_o`=0, `cfg_o`=0, `filt_o`=0x45, `stby_o`=0, `oscpd_o`=0 and `ready_o`=0.
- R2: While the port waits for a command, each input bit sampled as 1 is discarded. The first 0 is the gate bit, and the next seven bits are taken in this order: read flag (1 = read), standby, oscillator-off, two reserved zeros, then a 2-bit address. Address 0 is status on a read and is the command itself on a write, which has no data phase. Address 1 is configuration (24 bits), address 2 is filter (8 bits) and address 3 is the result (16 bits).
- R3: Every accepted command copies its standby bit to `stby_o` and its oscillator-off bit to `oscpd_o`. The status word reads as {ready, 5'b0, standby, 1'b0}.
- R4: A complete 24-bit write to address 1 updates `cfg_o`, and a following read of address 1 returns the same value.
- R5: A complete write to address 2 updates `filt_o` only if the standby bit is 1. Otherwise it is ignored and reads return the old value.
- R6: A pulse on `conv_valid_i` loads `conv_data_i` into the result register and sets `ready_o`. A write to address 3 does not change the result.
- R7: Reading all 16 bits of the result clears `ready_o`. A read aborted before the last bit leaves `ready_o` set.
- R8: `dout_o` changes after a falling serial clock edge and is valid before the next rising edge, most significant bit first. `dout_oe_o` is 1 only while the select is low.
- R9: Raising the select in the middle of a transfer abandons the transfer, commits no register, and leaves the port waiting for a command.
- R10: 32 consecutive sampled ones, counted across command and data phases within one select-low window, reset the port and all registers to their R1 values. A run of 31 ones does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles high |
| cs_ni | input | 1 | Active-low select |
| din_i | input | 1 | Serial data in, sampled on rising serial clock edge |
| dout_o | output | 1 | Serial data out |
| dout_oe_o | output | 1 | Output enable for `dout_o` (0 = high impedance) |
| conv_data_i | input | 16 | New conversion result |
| conv_valid_i | input | 1 | Loads `conv_data_i` and sets ready |
| cfg_o | output | 24 | Configuration register |
| filt_o | output | 8 | Filter register |
| stby_o | output | 1 | Standby control bit |
| oscpd_o | output | 1 | Oscillator power-down control bit |
| ready_o | output | 1 | Unread result present |

## Verification
The hardest case is a run of ones that crosses a transaction boundary. To reach it, the bench writes an all-ones configuration word, whose command already ends in a one, and then keeps the data line high through the gate idle. It then checks both sides of the threshold: a run of 31 keeps the committed word, and a run of 32 wipes it. A second hard case is a result read cut short by the select. The bench drives it by loading a result and raising the select after only eight data bits, then checking that the ready flag survives until a full read.

// File: rtl/sac_pkg.sv
package sac_pkg;
  typedef enum logic [1:0] {
    ADDR_STAT = 2'd0,
    ADDR_CFG  = 2'd1,
    ADDR_FILT = 2'd2,
    ADDR_DATA = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    ST_GATE = 2'd0,
    ST_CMD  = 2'd1,
    ST_XFER = 2'd2
  } port_state_e;

  typedef struct packed {
    logic       rd;
    logic       stby;
    logic       oscpd;
    logic [1:0] rsv;
    reg_addr_e  addr;
  } cmd_t;
endpackage

// File: rtl/sac_pin_sync.sv
module sac_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic din_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_s_o,
  output logic din_s_o
);
  localparam int unsigned NPIN = 3;
  localparam logic [NPIN-1:0] RST_VAL = 3'b011; // din, cs, sclk

  logic [NPIN-1:0] pin_in;
  logic [NPIN-1:0] stage_q [STAGES];
  logic            sclk_prev_q;

  assign pin_in = {din_i, cs_ni, sclk_i};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= pin_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_prev_q <= 1'b1;
    else sclk_prev_q <= stage_q[STAGES-1][0];
  end

  assign sclk_rise_o = stage_q[STAGES-1][0] & ~sclk_prev_q;
  assign sclk_fall_o = ~stage_q[STAGES-1][0] & sclk_prev_q;
  assign cs_s_o      = stage_q[STAGES-1][1];
  assign din_s_o     = stage_q[STAGES-1][2];
endmodule

// File: rtl/sac_shift_fsm.sv
module sac_shift_fsm
  import sac_pkg::*;
#(
  parameter int unsigned MAX_W  = 24,
  parameter int unsigned CFG_W  = 24,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned ONES_N = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             cs_s_i,
  input  logic             din_s_i,
  input  logic [MAX_W-1:0] rd_word_i,
  output reg_addr_e        sel_addr_o,
  output logic             cmd_acc_o,
  output cmd_t             cmd_o,
  output logic             wr_commit_o,
  output logic             rd_done_o,
  output reg_addr_e        xfer_addr_o,
  output logic [MAX_W-1:0] wdata_o,
  output logic             resync_o,
  output logic             dout_o
);
  localparam int unsigned CW = $clog2(MAX_W + 1);
  localparam int unsigned OW = $clog2(ONES_N + 1);
  localparam int unsigned CMD_BITS = 7;

  port_state_e         state_q;
  logic [CW-1:0]       cnt_q, len_q;
  logic [OW-1:0]       ones_q;
  logic [CMD_BITS-2:0] cmd_sr_q;
  logic [MAX_W-1:0]    rx_q, tx_q, rx_nxt;
  logic                rd_q, dout_q;
  reg_addr_e           addr_q;
  logic                live_rise, last_bit;

  function automatic logic [CW-1:0] len_of(reg_addr_e a);
    case (a)
      ADDR_CFG:  return CW'(CFG_W);
      ADDR_DATA: return CW'(DATA_W);
      default:   return CW'(REG_W);
    endcase
  endfunction

  assign live_rise = rise_i & ~cs_s_i;
  assign resync_o  = live_rise & din_s_i & (ones_q == OW'(ONES_N - 1));
  assign cmd_o     = cmd_t'({cmd_sr_q, din_s_i});
  assign sel_addr_o = cmd_o.addr;
  assign cmd_acc_o = live_rise & ~resync_o & (state_q == ST_CMD) &
                     (cnt_q == CW'(CMD_BITS - 1));
  assign last_bit  = live_rise & ~resync_o & (state_q == ST_XFER) &
                     (cnt_q == len_q - 1'b1);
  assign wr_commit_o = last_bit & ~rd_q;
  assign rd_done_o   = last_bit & rd_q;
  assign xfer_addr_o = addr_q;
  assign rx_nxt  = {rx_q[MAX_W-2:0], din_s_i};
  assign wdata_o = rx_nxt;
  assign dout_o  = dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_GATE;
      cnt_q    <= '0;
      len_q    <= CW'(REG_W);
      ones_q   <= '0;
      cmd_sr_q <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      rd_q     <= 1'b0;
      dout_q   <= 1'b0;
      addr_q   <= ADDR_STAT;
    end else if (cs_s_i) begin
      state_q <= ST_GATE;
      cnt_q   <= '0;
      ones_q  <= '0;
      dout_q  <= 1'b0;
    end else begin
      if (fall_i && state_q == ST_XFER && rd_q) begin
        dout_q <= tx_q[MAX_W-1];
        tx_q   <= tx_q << 1;
      end
      if (rise_i) begin
        if (!din_s_i) ones_q <= '0;
        else if (ones_q != OW'(ONES_N)) ones_q <= ones_q + 1'b1;
        if (resync_o) begin
          state_q <= ST_GATE;
          cnt_q   <= '0;
        end else begin
          case (state_q)
            ST_GATE: if (!din_s_i) begin
              state_q <= ST_CMD;
              cnt_q   <= '0;
            end
            ST_CMD: begin
              cmd_sr_q <= {cmd_sr_q[CMD_BITS-3:0], din_s_i};
              cnt_q    <= cnt_q + 1'b1;
              if (cmd_acc_o) begin
                cnt_q <= '0;
                if (!cmd_o.rd && cmd_o.addr == ADDR_STAT) begin
                  state_q <= ST_GATE;
                end else begin
                  state_q <= ST_XFER;
                  rd_q    <= cmd_o.rd;
                  addr_q  <= cmd_o.addr;
                  len_q   <= len_of(cmd_o.addr);
                  if (cmd_o.rd) tx_q <= rd_word_i;
                end
              end
            end
            ST_XFER: begin
              rx_q  <= rx_nxt;
              cnt_q <= cnt_q + 1'b1;
              if (last_bit) begin
                state_q <= ST_GATE;
                cnt_q   <= '0;
              end
            end
            default: state_q <= ST_GATE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sac_regfile.sv
module sac_regfile
  import sac_pkg::*;
#(
  parameter int unsigned MAX_W    = 24,
  parameter int unsigned CFG_W    = 24,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned REG_W    = 8,
  parameter logic [7:0]  FILT_RST = 8'h45
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              resync_i,
  input  logic              cmd_acc_i,
  input  cmd_t              cmd_i,
  input  logic              wr_commit_i,
  input  logic              rd_done_i,
  input  reg_addr_e         xfer_addr_i,
  input  logic [MAX_W-1:0]  wdata_i,
  input  reg_addr_e         sel_addr_i,
  output logic [MAX_W-1:0]  rd_word_o,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic              conv_valid_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [REG_W-1:0]  filt_o,
  output logic              stby_o,
  output logic              oscpd_o,
  output logic              ready_o
);
  logic [CFG_W-1:0]  cfg_q;
  logic [REG_W-1:0]  filt_q;
  logic [DATA_W-1:0] data_q;
  logic              stby_q, oscpd_q, ready_q;
  logic [REG_W-1:0]  status_w;

  assign status_w = REG_W'({ready_q, 5'b0, stby_q, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      filt_q  <= REG_W'(FILT_RST);
      data_q  <= '0;
      stby_q  <= 1'b0;
      oscpd_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      if (resync_i) begin
        cfg_q   <= '0;
        filt_q  <= REG_W'(FILT_RST);
        data_q  <= '0;
        stby_q  <= 1'b0;
        oscpd_q <= 1'b0;
        ready_q <= 1'b0;
      end else begin
        if (cmd_acc_i) begin
          stby_q  <= cmd_i.stby;
          oscpd_q <= cmd_i.oscpd;
        end
        if (wr_commit_i && xfer_addr_i == ADDR_CFG) cfg_q <= wdata_i[CFG_W-1:0];
        if (wr_commit_i && xfer_addr_i == ADDR_FILT && stby_q) filt_q <= wdata_i[REG_W-1:0];
        if (rd_done_i && xfer_addr_i == ADDR_DATA) ready_q <= 1'b0;
      end
      if (conv_valid_i) begin
        data_q  <= conv_data_i;
        ready_q <= 1'b1;
      end
    end
  end

  // read word is left-aligned so the serializer always starts at MAX_W-1
  always_comb begin
    case (sel_addr_i)
      ADDR_CFG:  rd_word_o = MAX_W'(cfg_q) << (MAX_W - CFG_W);
      ADDR_FILT: rd_word_o = MAX_W'(filt_q) << (MAX_W - REG_W);
      ADDR_DATA: rd_word_o = MAX_W'(data_q) << (MAX_W - DATA_W);
      default:   rd_word_o = MAX_W'(status_w) << (MAX_W - REG_W);
    endcase
  end

  assign cfg_o   = cfg_q;
  assign filt_o  = filt_q;
  assign stby_o  = stby_q;
  assign oscpd_o = oscpd_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/sac_serial_regs.sv
module sac_serial_regs
  import sac_pkg::*;
#(
  parameter int unsigned CFG_W    = 24,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned ONES_N   = 32,
  parameter int unsigned STAGES   = 2,
  parameter logic [7:0]  FILT_RST = 8'h45
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic              conv_valid_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [REG_W-1:0]  filt_o,
  output logic              stby_o,
  output logic              oscpd_o,
  output logic              ready_o
);
  localparam int unsigned MW0   = (CFG_W > DATA_W) ? CFG_W : DATA_W;
  localparam int unsigned MAX_W = (MW0 > REG_W) ? MW0 : REG_W;

  logic             rise_w, fall_w, cs_s_w, din_s_w;
  logic [MAX_W-1:0] rd_word_w, wdata_w;
  reg_addr_e        sel_addr_w, xfer_addr_w;
  cmd_t             cmd_w;
  logic             cmd_acc_w, wr_commit_w, rd_done_w, resync_w;

  sac_pin_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .din_i,
    .sclk_rise_o(rise_w), .sclk_fall_o(fall_w),
    .cs_s_o(cs_s_w), .din_s_o(din_s_w)
  );

  sac_shift_fsm #(
    .MAX_W(MAX_W), .CFG_W(CFG_W), .DATA_W(DATA_W), .REG_W(REG_W), .ONES_N(ONES_N)
  ) u_fsm (
    .clk_i, .rst_ni,
    .rise_i(rise_w), .fall_i(fall_w), .cs_s_i(cs_s_w), .din_s_i(din_s_w),
    .rd_word_i(rd_word_w), .sel_addr_o(sel_addr_w),
    .cmd_acc_o(cmd_acc_w), .cmd_o(cmd_w),
    .wr_commit_o(wr_commit_w), .rd_done_o(rd_done_w),
    .xfer_addr_o(xfer_addr_w), .wdata_o(wdata_w),
    .resync_o(resync_w), .dout_o(dout_o)
  );

  sac_regfile #(
    .MAX_W(MAX_W), .CFG_W(CFG_W), .DATA_W(DATA_W), .REG_W(REG_W), .FILT_RST(FILT_RST)
  ) u_regs (
    .clk_i, .rst_ni,
    .resync_i(resync_w), .cmd_acc_i(cmd_acc_w), .cmd_i(cmd_w),
    .wr_commit_i(wr_commit_w), .rd_done_i(rd_done_w),
    .xfer_addr_i(xfer_addr_w), .wdata_i(wdata_w),
    .sel_addr_i(sel_addr_w), .rd_word_o(rd_word_w),
    .conv_data_i, .conv_valid_i,
    .cfg_o, .filt_o, .stby_o, .oscpd_o, .ready_o
  );

  assign dout_oe_o = ~cs_s_w;
endmodule

// File: rtl/sac_serial_regs_chk.sv
module sac_serial_regs_chk #(
  parameter int unsigned CFG_W = 24,
  parameter int unsigned REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             dout_oe_o,
  input logic             conv_valid_i,
  input logic [CFG_W-1:0] cfg_o,
  input logic [REG_W-1:0] filt_o,
  input logic             stby_o,
  input logic             oscpd_o,
  input logic             ready_o,
  input logic             rd_done_w,
  input logic [1:0]       xfer_addr_w,
  input logic             resync_w
);
  // R8
  oe_off_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !dout_oe_o);

  // R5
  filt_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(stby_o) && !$past(resync_w)) |-> $stable(filt_o));

  // R6
  ready_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(conv_valid_i));

  // R7
  ready_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(resync_w || (rd_done_w && xfer_addr_w == 2'd3)));

  // R9
  cfg_hold_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |=>
      ($stable(cfg_o) && $stable(stby_o) && $stable(oscpd_o)));
endmodule

bind sac_serial_regs sac_serial_regs_chk #(.CFG_W(CFG_W), .REG_W(REG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .dout_oe_o(dout_oe_o),
  .conv_valid_i(conv_valid_i), .cfg_o(cfg_o), .filt_o(filt_o),
  .stby_o(stby_o), .oscpd_o(oscpd_o), .ready_o(ready_o),
  .rd_done_w(rd_done_w), .xfer_addr_w(xfer_addr_w), .resync_w(resync_w)
);

// File: tb/tb_sac_serial_regs.sv
module tb_sac_serial_regs;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
  logic dout, dout_oe;
  logic [15:0] conv_data = '0;
  logic conv_valid = 1'b0;
  logic [23:0] cfg;
  logic [7:0] filt;
  logic stby, oscpd, ready;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sac_serial_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe), .conv_data_i(conv_data),
    .conv_valid_i(conv_valid), .cfg_o(cfg), .filt_o(filt),
    .stby_o(stby), .oscpd_o(oscpd), .ready_o(ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic o);
    sclk = 1'b0; din = b;
    wait_clk(HALF);
    o = dout;
    sclk = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic sel;
    cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic desel;
    wait_clk(HALF); cs_n = 1'b1; din = 1'b0; wait_clk(HALF);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic o;
    for (int i = n - 1; i >= 0; i--) bit_xfer(v[i], o);
  endtask

  task automatic recv(input int n, output logic [31:0] v);
    logic o;
    v = '0;
    for (int i = 0; i < n; i++) begin
      bit_xfer(1'b0, o);
      v = {v[30:0], o};
    end
  endtask

  function automatic logic [7:0] cmd(input bit rd, input bit sb, input bit op,
                                      input logic [1:0] a);
    return {1'b0, rd, sb, op, 2'b00, a};
  endfunction

  function automatic int len_of(input logic [1:0] a);
    return (a == 2'd1) ? 24 : (a == 2'd3) ? 16 : 8;
  endfunction

  task automatic reg_write(input logic [1:0] a, input bit sb, input logic [23:0] d);
    sel; send(32'(cmd(0, sb, 0, a)), 8); send(32'(d), len_of(a)); desel;
  endtask

  task automatic reg_read(input logic [1:0] a, input bit sb, output logic [31:0] d);
    sel; send(32'(cmd(1, sb, 0, a)), 8); recv(len_of(a), d); desel;
  endtask

  // {stby, addr, data}
  localparam logic [26:0] VEC [6] = '{
    {1'b0, 2'd1, 24'hA5C3F0},
    {1'b0, 2'd2, 24'h000012},
    {1'b1, 2'd2, 24'h0000B7},
    {1'b1, 2'd1, 24'h123456},
    {1'b0, 2'd2, 24'h000099},
    {1'b0, 2'd1, 24'h5A0F3C}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [23:0] cfg_m;
    logic [7:0] filt_m;
    logic o;
    wait_clk(5); rst_ni = 1'b1; wait_clk(5);

    // R1 reset state
    check(cfg == 24'h0 && filt == 8'h45 && !stby && !oscpd && !ready && !dout_oe,
          "R1", {cfg, filt}, {24'h0, 8'h45});

    cfg_m = '0; filt_m = 8'h45;
    for (int i = 0; i < 6; i++) begin
      logic sb; logic [1:0] a; logic [23:0] d;
      {sb, a, d} = VEC[i];
      reg_write(a, sb, d);
      if (a == 2'd1) cfg_m = d;
      else if (sb) filt_m = d[7:0];
      reg_read(a, sb, rd);
      if (a == 2'd1) begin
        check(rd[23:0] == cfg_m && cfg == cfg_m, "R4 cfg readback", rd, 32'(cfg_m));
      end else begin
        check(rd[7:0] == filt_m && filt == filt_m, "R5 filt guard", rd, 32'(filt_m));
      end
    end

    // R3 power bits and status mirror
    sel; send(32'(cmd(0, 1, 1, 2'd0)), 8); desel;
    check(stby && oscpd, "R3 power bits", {stby, oscpd}, 2'b11);
    reg_read(2'd0, 1, rd);
    check(rd[7:0] == 8'h02, "R3 status stby", rd, 8'h02);

    // R2 leading ones idle before the gate bit
    sel; send(32'h7, 3); send(32'(cmd(0, 1, 0, 2'd1)), 8); send(32'hC0FFEE, 24); desel;
    check(cfg == 24'hC0FFEE, "R2 gate idle", cfg, 24'hC0FFEE);

    // R6 load result; write to result ignored
    @(negedge clk); conv_data = 16'hBEEF; conv_valid = 1'b1;
    @(negedge clk); conv_valid = 1'b0;
    check(ready, "R6 ready set", ready, 1);
    reg_write(2'd3, 1, 24'h001234);
    reg_read(2'd0, 1, rd);
    check(rd[7:0] == 8'h82, "R6 status ready", rd, 8'h82);

    // R7 partial read keeps ready, full read clears
    sel; send(32'(cmd(1, 1, 0, 2'd3)), 8); recv(8, rd); desel;
    check(rd[7:0] == 8'hBE && ready, "R7 partial read", {rd[7:0], 7'b0, ready}, {8'hBE, 8'h01});
    reg_read(2'd3, 1, rd);
    check(rd[15:0] == 16'hBEEF, "R8 msb first data", rd, 16'hBEEF);
    check(!ready, "R7 ready cleared", ready, 0);

    // R8 output enable follows select
    check(!dout_oe, "R8 oe idle", dout_oe, 0);
    sel; wait_clk(4);
    check(dout_oe, "R8 oe active", dout_oe, 1);
    desel;

    // R9 abort mid write
    sel; send(32'(cmd(0, 1, 0, 2'd1)), 8); send(32'h3FF, 10); desel;
    check(cfg == 24'hC0FFEE, "R9 abort no commit", cfg, 24'hC0FFEE);
    reg_read(2'd1, 1, rd);
    check(rd[23:0] == 24'hC0FFEE, "R9 next command ok", rd, 24'hC0FFEE);

    // R10 31 ones across boundary: no reset
    sel; send(32'(cmd(0, 1, 0, 2'd1)), 8); send(32'hFFFFFF, 24); send(32'h3F, 6); desel;
    check(cfg == 24'hFFFFFF && stby, "R10 31 ones kept", cfg, 24'hFFFFFF);
    // R10 32 ones: full reset
    sel; send(32'(cmd(0, 1, 0, 2'd2)), 8); send(32'h33, 8); desel;
    check(filt == 8'h33, "R5 filt write in standby", filt, 8'h33);
    sel; send(32'(cmd(0, 1, 0, 2'd1)), 8); send(32'hFFFFFF, 24); send(32'h7F, 7); desel;
    check(cfg == 24'h0 && filt == 8'h45 && !stby,
          "R10 32 ones reset", {cfg, filt}, {24'h0, 8'h45});

    // R10 port usable after resync
    reg_write(2'd1, 0, 24'h0A0B0C);
    check(cfg == 24'h0A0B0C, "R10 post resync write", cfg, 24'h0A0B0C);
    bit_xfer(1'b0, o);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule